// File: doc/BRIEF.md
# Decimated Parallel PRBS31 Generator and Error Checker

This block produces a maximal-length pseudo-random test pattern of period 2^31 − 1 in parallel form. Each enabled clock advances the underlying serial sequence by 32 bits. Lane i of the output word carries every 32nd serial bit, starting at offset i. The 32 lanes are therefore 32 phase-shifted copies of the same pattern, each decimated by 32.

Eight lanes, evenly spaced across the word, form a narrow output that feeds a downstream 8:1 serializer. Each of these lanes runs at one eighth of the serial line rate.

A companion error checker accepts a received 32-lane word. It seeds itself from the first valid word and then predicts every later word. It counts the mismatched bits and reports lock after a run of error-free words.

Top module: `prbs31_lane_gen`

## Requirements
- R1: On synchronous reset `word_o` is zero, `rx_lock_o` is low, `rx_err_cnt_o` is zero, and the generator history is all ones. The first enabled word after reset is therefore 32'h7000_0000.
- R2: The serial sequence obeys b[k] = b[k−31] XOR b[k−28], which is the polynomial x^31 + x^28 + 1. Each enabled cycle registers the next 32 serial bits into `word_o`, with bit i of the word holding serial bit 32·n + i, so bit 0 is the earliest.
- R3: While `seed_ld_i` is high, the history takes `seed_i`, with bit j being serial bit t−31+j (bit 0 is the oldest). Load wins over `gen_en_i`, and `word_o` holds during a load.
- R4: A zero seed is replaced by the all-ones history, so the generator history is never zero.
- R5: With `gen_en_i` and `seed_ld_i` both low, `word_o` holds and the sequence does not advance.
- R6: `ser_o[j]` equals `word_o[4·j]`, which spaces the 8 serializer lanes evenly across the 32.
- R7: The first word accepted with `rx_vld_i` high after reset seeds the checker from its upper 31 bits and is not counted. Words with `rx_vld_i` low change nothing.
- R8: Each later valid word adds its number of bit mismatches to `rx_err_cnt_o`. The prediction follows the checker's own sequence, so a corrupted word does not disturb the comparison of the words that follow.
- R9: `rx_lock_o` rises with the 64th consecutive error-free word after seeding. It drops on any word with an error, and the run then restarts from zero.
- R10: `rx_err_cnt_o` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| gen_en_i | input | 1 | Advance the generator by one word |
| seed_ld_i | input | 1 | Load `seed_i` into the generator history |
| seed_i | input | 31 | Seed history, bit 0 oldest |
| word_o | output | 32 | Parallel decimated pattern word |
| ser_o | output | 8 | Evenly spaced lanes for the 8:1 serializer |
| rx_vld_i | input | 1 | Received word is valid |
| rx_word_i | input | 32 | Received parallel word |
| rx_lock_o | output | 1 | Checker run of error-free words reached 64 |
| rx_err_cnt_o | output | 16 | Saturating count of bit mismatches |

## Verification
The properties assume that reset is held at the first clock edge. They also assume that `seed_ld_i` and `gen_en_i` are steady across each edge, since they relate the word output to those inputs in the previous cycle.

The checker properties assume that the mismatch count cannot grow by more than one word's worth of bits per cycle. They also assume that lock only follows an accepted word.

The stimulus drives every input on the falling edge and reads results one full cycle later. Received words are built from an independent serial model of the sequence, with deliberate bit-flip masks and invalid cycles carrying garbage data.

// File: rtl/prbs31_lane_pkg.sv
package prbs31_lane_pkg;
    localparam int unsigned PRBS_ORDER = 31;
    localparam int unsigned PRBS_TAP   = 28;
    localparam int unsigned WORD_LANES = 32;
    localparam int unsigned SER_WIDTH  = 8;
    localparam int unsigned LOCK_RUN   = 64;
    localparam int unsigned ERR_CNT_W  = 16;
endpackage

// File: rtl/prbs_unroll.sv
// Combinational advance of the recurrence by LANES steps.
module prbs_unroll #(
    parameter int unsigned ORDER = 31,
    parameter int unsigned TAP   = 28,
    parameter int unsigned LANES = 32
) (
    input  logic [ORDER-1:0] hist_i,
    output logic [LANES-1:0] bits_o,
    output logic [ORDER-1:0] hist_o
);
    localparam int unsigned OFS = ORDER - TAP;
    localparam int unsigned EXT = ORDER + LANES;

    logic [EXT-1:0] ext;

    always_comb begin
        ext = '0;
        ext[ORDER-1:0] = hist_i;
        for (int k = 0; k < LANES; k++) begin
            ext[ORDER+k] = ext[k] ^ ext[k+OFS];
        end
    end

    assign bits_o = ext[EXT-1:ORDER];
    assign hist_o = ext[EXT-1:LANES];
endmodule

// File: rtl/prbs_lane_gen.sv
module prbs_lane_gen #(
    parameter int unsigned     ORDER    = 31,
    parameter int unsigned     TAP      = 28,
    parameter int unsigned     LANES    = 32,
    parameter logic [ORDER-1:0] DEF_SEED = '1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             ld_i,
    input  logic [ORDER-1:0] seed_i,
    output logic [LANES-1:0] word_o,
    output logic [ORDER-1:0] hist_o
);
    typedef struct packed {
        logic [ORDER-1:0] hist;
        logic [LANES-1:0] word;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [LANES-1:0] nxt_bits;
    logic [ORDER-1:0] nxt_hist;

    prbs_unroll #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_adv (
        .hist_i (gen_q.hist),
        .bits_o (nxt_bits),
        .hist_o (nxt_hist)
    );

    always_comb begin
        gen_d = gen_q;
        if (ld_i) begin
            gen_d.hist = (seed_i == '0) ? DEF_SEED : seed_i;
        end else if (en_i) begin
            gen_d.hist = nxt_hist;
            gen_d.word = nxt_bits;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gen_q.hist <= DEF_SEED;
            gen_q.word <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign word_o = gen_q.word;
    assign hist_o = gen_q.hist;
endmodule

// File: rtl/prbs_lane_chk.sv
module prbs_lane_chk #(
    parameter int unsigned ORDER      = 31,
    parameter int unsigned TAP        = 28,
    parameter int unsigned LANES      = 32,
    parameter int unsigned LOCK_WORDS = 64,
    parameter int unsigned CNT_W      = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             vld_i,
    input  logic [LANES-1:0] word_i,
    output logic             lock_o,
    output logic [CNT_W-1:0] errs_o
);
    localparam int unsigned RUN_W  = $clog2(LOCK_WORDS + 1);
    localparam int unsigned MISS_W = $clog2(LANES + 1);

    typedef struct packed {
        logic             synced;
        logic [ORDER-1:0] hist;
        logic [RUN_W-1:0] run;
        logic             locked;
        logic [CNT_W-1:0] errs;
    } chk_t;

    chk_t chk_d, chk_q;
    logic [LANES-1:0] exp_bits;
    logic [ORDER-1:0] exp_hist;
    logic [MISS_W-1:0] miss;
    logic [CNT_W:0]    sum;

    prbs_unroll #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_pred (
        .hist_i (chk_q.hist),
        .bits_o (exp_bits),
        .hist_o (exp_hist)
    );

    always_comb begin
        miss  = MISS_W'($countones(word_i ^ exp_bits));
        sum   = {1'b0, chk_q.errs} + {{(CNT_W + 1 - MISS_W){1'b0}}, miss};
        chk_d = chk_q;
        if (vld_i) begin
            if (!chk_q.synced) begin
                chk_d.synced = 1'b1;
                chk_d.hist   = word_i[LANES-1 -: ORDER];
                chk_d.run    = '0;
            end else begin
                chk_d.hist = exp_hist;
                if (miss != '0) begin
                    chk_d.run  = '0;
                    chk_d.errs = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
                end else if (chk_q.run != RUN_W'(LOCK_WORDS)) begin
                    chk_d.run = chk_q.run + RUN_W'(1);
                end
            end
        end
        chk_d.locked = (chk_d.run == RUN_W'(LOCK_WORDS));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chk_q <= '0;
        end else begin
            chk_q <= chk_d;
        end
    end

    assign lock_o = chk_q.locked;
    assign errs_o = chk_q.errs;
endmodule

// File: rtl/prbs31_lane_gen.sv
module prbs31_lane_gen
    import prbs31_lane_pkg::*;
#(
    parameter int unsigned ORDER      = PRBS_ORDER,
    parameter int unsigned TAP        = PRBS_TAP,
    parameter int unsigned LANES      = WORD_LANES,
    parameter int unsigned SER_LANES  = SER_WIDTH,
    parameter int unsigned LOCK_WORDS = LOCK_RUN,
    parameter int unsigned CNT_W      = ERR_CNT_W
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 gen_en_i,
    input  logic                 seed_ld_i,
    input  logic [ORDER-1:0]     seed_i,
    output logic [LANES-1:0]     word_o,
    output logic [SER_LANES-1:0] ser_o,
    input  logic                 rx_vld_i,
    input  logic [LANES-1:0]     rx_word_i,
    output logic                 rx_lock_o,
    output logic [CNT_W-1:0]     rx_err_cnt_o
);
    localparam int unsigned STRIDE = LANES / SER_LANES;

    logic [ORDER-1:0] gen_hist;

    prbs_lane_gen #(
        .ORDER    (ORDER),
        .TAP      (TAP),
        .LANES    (LANES),
        .DEF_SEED ({ORDER{1'b1}})
    ) u_gen (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (gen_en_i),
        .ld_i   (seed_ld_i),
        .seed_i (seed_i),
        .word_o (word_o),
        .hist_o (gen_hist)
    );

    for (genvar j = 0; j < SER_LANES; j++) begin : g_ser
        assign ser_o[j] = word_o[j*STRIDE];
    end

    prbs_lane_chk #(
        .ORDER      (ORDER),
        .TAP        (TAP),
        .LANES      (LANES),
        .LOCK_WORDS (LOCK_WORDS),
        .CNT_W      (CNT_W)
    ) u_chk (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .vld_i  (rx_vld_i),
        .word_i (rx_word_i),
        .lock_o (rx_lock_o),
        .errs_o (rx_err_cnt_o)
    );
endmodule

// File: rtl/prbs31_lane_gen_sva.sv
module prbs31_lane_gen_sva #(
    parameter int unsigned ORDER = 31,
    parameter int unsigned LANES = 32,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             gen_en_i,
    input logic             seed_ld_i,
    input logic [LANES-1:0] word_o,
    input logic [ORDER-1:0] gen_hist,
    input logic             rx_vld_i,
    input logic             rx_lock_o,
    input logic [CNT_W-1:0] rx_err_cnt_o
);
    a_r5_idle_holds_word: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gen_en_i && !seed_ld_i) |=> $stable(word_o));

    a_r3_load_holds_word: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_ld_i |=> $stable(word_o));

    a_r4_history_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        gen_hist != '0);

    a_r10_count_never_falls: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (rx_err_cnt_o >= $past(rx_err_cnt_o)));

    a_r8_count_step_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((rx_err_cnt_o - $past(rx_err_cnt_o)) <= CNT_W'(LANES)));

    a_r9_error_clears_lock: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_err_cnt_o != $past(rx_err_cnt_o)) |-> !rx_lock_o);

    a_r9_lock_follows_word: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rx_lock_o) |-> $past(rx_vld_i));
endmodule

bind prbs31_lane_gen prbs31_lane_gen_sva #(
    .ORDER (ORDER),
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_sva (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .gen_en_i     (gen_en_i),
    .seed_ld_i    (seed_ld_i),
    .word_o       (word_o),
    .gen_hist     (gen_hist),
    .rx_vld_i     (rx_vld_i),
    .rx_lock_o    (rx_lock_o),
    .rx_err_cnt_o (rx_err_cnt_o)
);

// File: tb/prbs31_lane_gen_tb.sv
module prbs31_lane_gen_tb;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        gen_en_i = 1'b0;
    logic        seed_ld_i = 1'b0;
    logic [30:0] seed_i = '0;
    logic [31:0] word_o;
    logic [7:0]  ser_o;
    logic        rx_vld_i = 1'b0;
    logic [31:0] rx_word_i = '0;
    logic        rx_lock_o;
    logic [15:0] rx_err_cnt_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    prbs31_lane_gen u_dut (
        .clk_i        (clk),
        .rst_i        (rst_i),
        .gen_en_i     (gen_en_i),
        .seed_ld_i    (seed_ld_i),
        .seed_i       (seed_i),
        .word_o       (word_o),
        .ser_o        (ser_o),
        .rx_vld_i     (rx_vld_i),
        .rx_word_i    (rx_word_i),
        .rx_lock_o    (rx_lock_o),
        .rx_err_cnt_o (rx_err_cnt_o)
    );

    // {load, seed, enable}
    localparam logic [32:0] VEC [0:14] = '{
        {1'b0, 31'h0000000, 1'b1},
        {1'b0, 31'h0000000, 1'b1},
        {1'b0, 31'h0000000, 1'b0},
        {1'b0, 31'h0000000, 1'b1},
        {1'b1, 31'h1234567, 1'b0},
        {1'b0, 31'h0000000, 1'b1},
        {1'b1, 31'h0000001, 1'b1},
        {1'b0, 31'h0000000, 1'b1},
        {1'b0, 31'h0000000, 1'b1},
        {1'b1, 31'h0000000, 1'b0},
        {1'b0, 31'h0000000, 1'b1},
        {1'b0, 31'h0000000, 1'b0},
        {1'b0, 31'h0000000, 1'b1},
        {1'b1, 31'h2AAAAAAA, 1'b1},
        {1'b0, 31'h0000000, 1'b1}
    };

    // Bit-serial model: history bit 0 oldest, new bit = b[k-31] ^ b[k-28]
    function automatic void ref_adv(inout logic [30:0] h, output logic [31:0] w);
        w = '0;
        for (int k = 0; k < 32; k++) begin
            logic nb;
            nb   = h[0] ^ h[3];
            w[k] = nb;
            h    = {nb, h[30:1]};
        end
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ser_of(input logic [31:0] w);
        logic [7:0] s;
        for (int j = 0; j < 8; j++) s[j] = w[4*j];
        return s;
    endfunction

    task automatic rx_send(input logic vld, input logic [31:0] w);
        rx_vld_i  = vld;
        rx_word_i = w;
        @(negedge clk);
        rx_vld_i  = 1'b0;
    endtask

    logic [30:0] g_hist;
    logic [31:0] g_word;
    logic [30:0] r_hist;
    logic [31:0] r_word;

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset word", {32'h0, word_o}, 64'h0);
        check("R1 reset lock", {63'h0, rx_lock_o}, 64'h0);
        check("R1 reset count", {48'h0, rx_err_cnt_o}, 64'h0);
        rst_i = 1'b0;

        // table walk for the generator
        g_hist = '1;
        g_word = '0;
        for (int v = 0; v < 15; v++) begin
            seed_ld_i = VEC[v][32];
            seed_i    = VEC[v][31:1];
            gen_en_i  = VEC[v][0];
            @(negedge clk);
            if (VEC[v][32]) begin
                g_hist = (VEC[v][31:1] == '0) ? '1 : VEC[v][31:1];
                check("R3/R4 load holds word", {32'h0, word_o}, {32'h0, g_word});
            end else if (VEC[v][0]) begin
                ref_adv(g_hist, g_word);
                check("R2 word vs serial model", {32'h0, word_o}, {32'h0, g_word});
            end else begin
                check("R5 idle holds word", {32'h0, word_o}, {32'h0, g_word});
            end
            if (v == 0) check("R1 first word", {32'h0, word_o}, 64'h7000_0000);
            check("R6 serializer lanes", {56'h0, ser_o}, {56'h0, ser_of(g_word)});
        end
        seed_ld_i = 1'b0;
        gen_en_i  = 1'b1;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            ref_adv(g_hist, g_word);
            check("R2 long run", {32'h0, word_o}, {32'h0, g_word});
            check("R6 long run", {56'h0, ser_o}, {56'h0, ser_of(g_word)});
        end
        gen_en_i = 1'b0;

        // mid-run reset of the generator
        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        check("R1 reset mid run", {32'h0, word_o}, 64'h0);
        gen_en_i = 1'b1;
        @(negedge clk);
        gen_en_i = 1'b0;
        check("R1 default seed after reset", {32'h0, word_o}, 64'h7000_0000);

        // checker: seed word
        r_hist = 31'h5A5A5A5;
        ref_adv(r_hist, r_word);
        rx_send(1'b1, r_word);
        check("R7 seed word not counted", {48'h0, rx_err_cnt_o}, 64'h0);
        rx_send(1'b0, 32'hDEAD_BEEF);
        check("R7 invalid word ignored", {48'h0, rx_err_cnt_o}, 64'h0);
        for (int n = 0; n < 63; n++) begin
            ref_adv(r_hist, r_word);
            rx_send(1'b1, r_word);
        end
        check("R9 no lock at 63", {63'h0, rx_lock_o}, 64'h0);
        check("R8 clean stream count", {48'h0, rx_err_cnt_o}, 64'h0);
        ref_adv(r_hist, r_word);
        rx_send(1'b1, r_word);
        check("R9 lock at 64", {63'h0, rx_lock_o}, 64'h1);

        ref_adv(r_hist, r_word);
        rx_send(1'b1, r_word ^ 32'h8000_0101);
        check("R8 three bit errors", {48'h0, rx_err_cnt_o}, 64'd3);
        check("R9 error drops lock", {63'h0, rx_lock_o}, 64'h0);
        for (int n = 0; n < 10; n++) begin
            ref_adv(r_hist, r_word);
            rx_send(1'b1, r_word);
            rx_send(1'b0, 32'hFFFF_FFFF);
        end
        check("R8 tracking after error", {48'h0, rx_err_cnt_o}, 64'd3);
        for (int n = 0; n < 53; n++) begin
            ref_adv(r_hist, r_word);
            rx_send(1'b1, r_word);
        end
        check("R9 run restarted, 63 clean", {63'h0, rx_lock_o}, 64'h0);
        ref_adv(r_hist, r_word);
        rx_send(1'b1, r_word);
        check("R9 relock at 64", {63'h0, rx_lock_o}, 64'h1);

        ref_adv(r_hist, r_word);
        rx_send(1'b1, ~r_word);
        check("R8 full word error", {48'h0, rx_err_cnt_o}, 64'd35);
        for (int n = 0; n < 2100; n++) begin
            ref_adv(r_hist, r_word);
            rx_send(1'b1, ~r_word);
        end
        check("R10 saturated count", {48'h0, rx_err_cnt_o}, 64'hFFFF);
        check("R10 no lock while failing", {63'h0, rx_lock_o}, 64'h0);

        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        check("R1 checker reset count", {48'h0, rx_err_cnt_o}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule